// File: doc/BRIEF.md
# Divide-by-Ten Reciprocal Multiplier

This block divides an unsigned integer by ten without a divider circuit. Each input word is multiplied by a fixed-point approximation of one tenth. The upper half of the double-width product is kept and shifted right by three places, which gives the integer quotient. The remainder is then formed by multiplying the quotient back by ten and subtracting that from the input.

The datapath is a straight three-stage pipeline and has no stall. A word presented with its valid flag on a rising edge gives a quotient, a remainder and a raised output valid three edges later. A new word can be accepted on every cycle, and idle cycles pass through the pipeline as gaps.

The data width `W` is a parameter, and the reciprocal constant is derived from it. The reset is synchronous and clears only the valid flags, so any work in flight is dropped. The data registers are not reset.

Top module: `d10_divider`

## Requirements
- R1: For every W-bit unsigned input x, from 0 up to and including 2^W-1, `out_quot` equals floor(x/10).
- R2: `out_rem` is a 4-bit value equal to x minus ten times `out_quot`, and it always lies in the range 0 to 9.
- R3: When `in_valid` is high at a rising edge, `out_valid` is high after the third rising edge counted from that one, and `out_quot`/`out_rem` then hold the results for that input. This holds on every cycle of an unbroken stream.
- R4: When `in_valid` is low at a rising edge, `out_valid` is low after the third rising edge counted from that one. Gaps in the input stream therefore appear at the output in the same positions.
- R5: When `rst` is high at a rising edge, all three pipeline valid flags are cleared. `out_valid` is low after that edge, and no input accepted before the reset ever appears at the output.
- R6: The multiplier constant is ceil(2^(W+3)/10), which is 0xCCCCCCCD for W=32. The quotient is the upper W bits of the 2W-bit unsigned product, shifted right by 3, and it is exact at the extremes of the 32-bit range (for example 0xFFFFFFFF gives 429496729 remainder 5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the valid flags |
| in_valid | input | 1 | Marks `in_data` as a word to divide |
| in_data | input | W | Unsigned dividend |
| out_valid | output | 1 | Marks `out_quot` and `out_rem` as a result |
| out_quot | output | W | Quotient floor(in_data/10) |
| out_rem | output | 4 | Remainder in the range 0 to 9 |

## Verification
The bench builds one instance with W=16, which makes an exhaustive sweep of all 65536 dividends possible, including both ends of the range. A second instance with W=32 uses the constant 0xCCCCCCCD and runs alongside the first. It receives scrambled dividends and a set of extreme values where the reciprocal error is largest, such as 0xFFFFFFFF and 0xFFFFFFF9. Both instances also see streams with gaps and a reset raised while data is in flight, so the valid timing can be checked against a model of the pipeline kept in the bench.

// File: rtl/d10_pkg.sv
package d10_pkg;

    localparam int REM_W = 4;

    // Fixed-point reciprocal of ten, scaled by 2^(w+3), rounded up.
    function automatic logic [63:0] recip_const(input int unsigned w);
        return ((64'd1 << (w + 3)) + 64'd9) / 64'd10;
    endfunction

endpackage

// File: rtl/d10_capture.sv
module d10_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic [W-1:0] x_i,
    output logic         v_q,
    output logic [W-1:0] x_q
);

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_i;
    end

    always_ff @(posedge clk) begin
        x_q <= x_i;
    end

    // R5: a reset edge leaves the first stage empty
    assert_reset_clears_R5: assert property (@(posedge clk) rst |=> !v_q);

endmodule

// File: rtl/d10_recip_mul.sv
module d10_recip_mul #(
    parameter int           W     = 32,
    parameter logic [W-1:0] RECIP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic [W-1:0] x_i,
    output logic         v_q,
    output logic [W-1:0] x_q,
    output logic [W-1:0] hi_q
);

    localparam int PW = 2 * W;

    logic [W-1:0] hi_next;

    always_comb begin
        hi_next = W'((PW'(x_i) * PW'(RECIP)) >> W);
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_i;
    end

    always_ff @(posedge clk) begin
        x_q  <= x_i;
        hi_q <= hi_next;
    end

    // R6: the scaled reciprocal is slightly above 0.8, so the high word never exceeds the input
    assert_hi_bound_R6: assert property (@(posedge clk) disable iff (rst)
        v_q |-> (hi_q <= x_q));

endmodule

// File: rtl/d10_quot_rem.sv
module d10_quot_rem #(
    parameter int W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     v_i,
    input  logic [W-1:0]             x_i,
    input  logic [W-1:0]             hi_i,
    output logic                     v_q,
    output logic [W-1:0]             q_q,
    output logic [d10_pkg::REM_W-1:0] r_q
);

    import d10_pkg::*;

    logic [W-1:0]     q_next;
    logic [REM_W-1:0] r_next;

    always_comb begin
        q_next = hi_i >> 3;
        // ten times q is (q << 3) + (q << 1); only the low bits survive
        r_next = REM_W'(x_i - ((q_next << 3) + (q_next << 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_i;
    end

    always_ff @(posedge clk) begin
        q_q <= q_next;
        r_q <= r_next;
    end

    // R2: remainder stays below the divisor
    assert_rem_range_R2: assert property (@(posedge clk) disable iff (rst)
        v_q |-> (r_q < REM_W'(10)));

endmodule

// File: rtl/d10_divider.sv
module d10_divider #(
    parameter int W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [W-1:0]              in_data,
    output logic                      out_valid,
    output logic [W-1:0]              out_quot,
    output logic [d10_pkg::REM_W-1:0] out_rem
);

    import d10_pkg::*;

    localparam logic [63:0]  RECIP_FULL = recip_const(W);
    localparam logic [W-1:0] RECIP      = RECIP_FULL[W-1:0];

    logic         s1_v;
    logic [W-1:0] s1_x;
    logic         s2_v;
    logic [W-1:0] s2_x;
    logic [W-1:0] s2_hi;

    d10_capture #(.W(W)) u_capture (
        .clk (clk),
        .rst (rst),
        .v_i (in_valid),
        .x_i (in_data),
        .v_q (s1_v),
        .x_q (s1_x)
    );

    d10_recip_mul #(.W(W), .RECIP(RECIP)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .v_i  (s1_v),
        .x_i  (s1_x),
        .v_q  (s2_v),
        .x_q  (s2_x),
        .hi_q (s2_hi)
    );

    d10_quot_rem #(.W(W)) u_quot_rem (
        .clk  (clk),
        .rst  (rst),
        .v_i  (s2_v),
        .x_i  (s2_x),
        .hi_i (s2_hi),
        .v_q  (out_valid),
        .q_q  (out_quot),
        .r_q  (out_rem)
    );

    // R3: an accepted word emerges three edges later
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R4: an idle cycle emerges as a gap three edges later
    assert_gap_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

    // R1: quotient and remainder rebuild the dividend from three cycles back
    assert_exact_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((64'(out_quot) * 64'd10 + 64'(out_rem)) == 64'($past(in_data, 3))));

endmodule

// File: tb/tb_d10_divider.sv
`timescale 1ns/1ps
module tb_d10_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iv  = 1'b0;
    logic [15:0] a16 = '0;
    logic [31:0] a32 = '0;

    logic        ov16;
    logic [15:0] q16;
    logic [3:0]  r16;
    logic        ov32;
    logic [31:0] q32;
    logic [3:0]  r32;

    always #5 clk = ~clk;

    d10_divider #(.W(16)) dut (
        .clk(clk), .rst(rst), .in_valid(iv), .in_data(a16),
        .out_valid(ov16), .out_quot(q16), .out_rem(r16)
    );

    d10_divider #(.W(32)) dut32 (
        .clk(clk), .rst(rst), .in_valid(iv), .in_data(a32),
        .out_valid(ov32), .out_quot(q32), .out_rem(r32)
    );

    int checks = 0;
    int errors = 0;
    int since_rst = 0;

    logic        mv  [3];
    logic [15:0] m16 [3];
    logic [31:0] m32 [3];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v,
                        input logic [31:0] x32, input logic [15:0] x16);
        string vtag;
        rst = r;
        iv  = v;
        a16 = x16;
        a32 = x32;
        @(posedge clk);
        #1;
        if (r) begin
            for (int k = 0; k < 3; k++) mv[k] = 1'b0;
            since_rst = 0;
        end else begin
            for (int k = 2; k > 0; k--) begin
                mv[k]  = mv[k-1];
                m16[k] = m16[k-1];
                m32[k] = m32[k-1];
            end
            mv[0]  = v;
            m16[0] = x16;
            m32[0] = x32;
            since_rst++;
        end
        @(negedge clk);
        if (mv[2])             vtag = "R3";
        else if (since_rst < 3) vtag = "R5";
        else                    vtag = "R4";
        chk(vtag, "valid16", 64'(ov16), 64'(mv[2]));
        chk(vtag, "valid32", 64'(ov32), 64'(mv[2]));
        if (mv[2]) begin
            chk("R1", "quot16", 64'(q16), 64'(m16[2] / 16'd10));
            chk("R2", "rem16",  64'(r16), 64'(m16[2] % 16'd10));
            chk("R6", "quot32", 64'(q32), 64'(m32[2] / 32'd10));
            chk("R2", "rem32",  64'(r32), 64'(m32[2] % 32'd10));
        end
    endtask

    function automatic logic [31:0] corner(input int n);
        case (n)
            0:  return 32'h0000_0000;
            1:  return 32'h0000_0001;
            2:  return 32'h0000_0009;
            3:  return 32'h0000_000A;
            4:  return 32'hFFFF_FFFF;
            5:  return 32'hFFFF_FFFE;
            6:  return 32'hFFFF_FFF9;
            7:  return 32'hFFFF_FFFA;
            8:  return 32'h7FFF_FFFF;
            9:  return 32'h8000_0000;
            10: return 32'hCCCC_CCCC;
            11: return 32'h9999_9999;
            12: return 32'd4294967289;
            default: return 32'd1000000009;
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            mv[k] = 1'b0; m16[k] = '0; m32[k] = '0;
        end
        // reset state, R5
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 32'hFFFF_FFFF, 16'hFFFF);
        step(1'b0, 1'b0, '0, '0);
        // exhaustive sweep of the 16-bit instance, R1 R2 R3; scrambled 32-bit words
        for (int i = 0; i < 65536; i++) begin
            logic [31:0] u;
            u = 32'(i);
            step(1'b0, 1'b1, (u * 32'h9E37_79B9) ^ (u << 20), u[15:0]);
        end
        // gaps in the stream, R4
        for (int j = 0; j < 45; j++) begin
            logic [31:0] u;
            u = 32'(j) * 32'd97 + 32'd3;
            step(1'b0, (j % 3) != 0, ~u, u[15:0]);
        end
        // reset with words in flight, R5
        for (int j = 0; j < 5; j++) step(1'b0, 1'b1, 32'd12345 + 32'(j), 16'(j + 500));
        step(1'b1, 1'b1, 32'd777, 16'd777);
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, 32'd1, 16'd1);
        // extreme 32-bit dividends, R6
        for (int n = 0; n < 14; n++) begin
            logic [31:0] c;
            c = corner(n);
            step(1'b0, 1'b1, c, c[15:0]);
        end
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, '0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule